// File: doc/BRIEF.md
# Sixteen-bit multicycle processor core

This block is a small accumulator-free register machine that runs 16-bit instructions out of one shared word memory. Code and data sit in the same 128-word array, and both are addressed by a 7-bit word address. The core holds seven general registers and one flag word. It walks each instruction through a fetch cycle and an execute cycle, and it stops for good on a halt instruction until the next reset.

The memory is kept inside the block. A load port fills it while reset is held, and a combinational peek port lets the surrounding logic read any word back, for example after the program has halted. Every executed instruction produces a one-cycle retire pulse. The pulse carries that instruction's address and the register and flag values the instruction left behind. A verification environment can compare this trace line by line against an instruction-level model.

Top module: `cpu16_core`

## Requirements
- R1: The opcode is in bits 15..11. The fields are placed as follows:
  - Three-register ops: destination in bits 8..6, first source in 5..3, second source in 2..0.
  - Register/immediate and register/address ops: register in bits 9..7, 7-bit value in 6..0.
  - Two-register ops: first register in 5..3, second in 2..0.
  - Jumps: target in 6..0.
  - Bits not named for an op have no effect.
- R2: add (00000), sub (00001) and mul (00110) write the unsigned result. When add or mul overflows 16 bits, or when sub's second operand exceeds its first, they write 0 and set V (FLAGS bit 3).
- R3: div (00111) divides the register in 5..3 by the register in 2..0. The quotient goes to R0 and the remainder to R1. A zero divisor writes 0 to both and sets V.
- R4: mov-immediate (00010) writes the 7-bit value zero-extended. Right shift (01000) and left shift (01001) shift the register by the 7-bit amount, and an amount of 16 or more gives 0.
- R5: xor (01010), or (01011) and and (01100) combine two registers. not (01101) writes the inverse of the register in 2..0 into the register in 5..3.
- R6: cmp (01110) compares the register in 5..3 (x) with the one in 2..0 (y). It sets L (bit 2) when x<y, G (bit 1) when x>y and E (bit 0) when they are equal. FLAGS bits 15..4 always read 0.
- R7: Each instruction replaces FLAGS with the flags it produces. An instruction that sets no flag, including a jump, leaves FLAGS all zero.
- R8: Register codes 000..110 name R0..R6, and 111 names FLAGS. A register move (00011) from code 111 copies the FLAGS word into the destination in 5..3.
- R9: ld (00100) loads the word at the 7-bit address into the register in 9..7. st (00101) writes that register to the address, and the peek port shows the stored word.
- R10: jmp (01111) always jumps. jlt (11100), jgt (11101) and je (11111) jump when L, G or E respectively was left by the previous instruction. Otherwise the PC steps by one and wraps from 127 to 0.
- R11: While reset is held, the PC, all registers and FLAGS are zero, halted is low and no retire is shown.
- R12: Each instruction takes exactly two cycles. retire_valid is a one-cycle pulse showing that instruction's PC and the register and flag values after it.
- R13: hlt (11010) retires once. After that, halted stays high, no further retire occurs and no state changes until reset.
- R14: Opcodes outside the listed set change no register or memory word, clear FLAGS and advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write load_data into memory at load_addr |
| load_addr | input | 7 | Load word address |
| load_data | input | 16 | Load word |
| peek_addr | input | 7 | Read-back word address |
| peek_data | output | 16 | Memory word at peek_addr |
| retire_valid | output | 1 | One-cycle pulse per executed instruction |
| retire_pc | output | 7 | Address of the retired instruction |
| retire_gpr | output | 112 | R0..R6 after the instruction, R(i) in bits 16i+15..16i |
| retire_flags | output | 16 | FLAGS word after the instruction |
| halted | output | 1 | High once hlt has retired |

## Verification
The assertions cover the behaviours that hold on every cycle:
- the retire pulse lasts one cycle and is never followed directly by another;
- halted is sticky, with no retire while halted;
- the flag word keeps its layout and at most one compare bit is set;
- the reset state appears after reset;
- the PC either steps by one or lands on the jump target after an execute cycle.

Arithmetic results, overflow handling, division, flag clearing, FLAGS reads and the memory contents are checked only by the bench's scenarios. The bench runs random programs with random filler in the unused bits, plus a directed program and a wrap-around loop, and compares each retire against its own instruction model.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int DW     = 16;
    localparam int AW     = 7;
    localparam int RCW    = 3;
    localparam int NGPR   = 7;
    localparam int OPW    = 5;
    localparam int NFLAG  = 4;
    localparam int DEPTH  = 1 << AW;

    typedef logic [DW-1:0]  word_t;
    typedef logic [AW-1:0]  addr_t;
    typedef logic [RCW-1:0] rcode_t;

    localparam rcode_t FLAGS_CODE = rcode_t'((1 << RCW) - 1);

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'b00000,
        OP_SUB  = 5'b00001,
        OP_MOVI = 5'b00010,
        OP_MOVR = 5'b00011,
        OP_LD   = 5'b00100,
        OP_ST   = 5'b00101,
        OP_MUL  = 5'b00110,
        OP_DIV  = 5'b00111,
        OP_RS   = 5'b01000,
        OP_LS   = 5'b01001,
        OP_XOR  = 5'b01010,
        OP_OR   = 5'b01011,
        OP_AND  = 5'b01100,
        OP_NOT  = 5'b01101,
        OP_CMP  = 5'b01110,
        OP_JMP  = 5'b01111,
        OP_JLT  = 5'b11100,
        OP_JGT  = 5'b11101,
        OP_HLT  = 5'b11010,
        OP_JE   = 5'b11111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_HALT
    } state_e;

    // Packed order gives V at bit 3, L at 2, G at 1, E at 0.
    typedef struct packed {
        logic v;
        logic lt;
        logic gt;
        logic eq;
    } flags_t;

    typedef struct packed {
        rcode_t ra;
        rcode_t rb;
        rcode_t rd;
        logic   wr;
        logic   wr_pair;
        logic   is_ld;
        logic   is_st;
        logic   is_jump;
        logic   is_halt;
    } decode_t;

    function automatic word_t flags_word(flags_t f);
        return {{(DW-NFLAG){1'b0}}, f};
    endfunction

    function automatic decode_t decode(word_t ir);
        decode_t d;
        d    = '0;
        d.ra = ir[5:3];
        d.rb = ir[2:0];
        d.rd = ir[5:3];
        case (opcode_e'(ir[DW-1 -: OPW]))
            OP_ADD, OP_SUB, OP_MUL, OP_XOR, OP_OR, OP_AND: begin
                d.rd = ir[8:6];
                d.wr = 1'b1;
            end
            OP_MOVI, OP_RS, OP_LS: begin
                d.ra = ir[9:7];
                d.rd = ir[9:7];
                d.wr = 1'b1;
            end
            OP_LD: begin
                d.ra    = ir[9:7];
                d.rd    = ir[9:7];
                d.wr    = 1'b1;
                d.is_ld = 1'b1;
            end
            OP_ST: begin
                d.ra    = ir[9:7];
                d.is_st = 1'b1;
            end
            OP_MOVR, OP_NOT: d.wr = 1'b1;
            OP_DIV:          d.wr_pair = 1'b1;
            OP_JMP, OP_JLT, OP_JGT, OP_JE: d.is_jump = 1'b1;
            OP_HLT:          d.is_halt = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cpu16_mem.sv
module cpu16_mem #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
    assign pdata = cells[paddr];
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int NREG = 7,
    parameter int W    = 16,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we0,
    input  logic [CW-1:0]   wa0,
    input  logic [W-1:0]    wd0,
    input  logic            we1,
    input  logic [CW-1:0]   wa1,
    input  logic [W-1:0]    wd1,
    input  logic [CW-1:0]   ra0,
    output logic [W-1:0]    rd0,
    input  logic [CW-1:0]   ra1,
    output logic [W-1:0]    rd1,
    output logic [NREG*W-1:0] dump
);
    localparam int NCODE = 1 << CW;

    logic [W-1:0] rv [NCODE];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we1 && wa1 == CW'(i)) begin
                q <= wd1;
            end else if (we0 && wa0 == CW'(i)) begin
                q <= wd0;
            end
        end
        assign rv[i]            = q;
        assign dump[i*W +: W]   = q;
    end

    for (genvar j = NREG; j < NCODE; j++) begin : g_void
        assign rv[j] = '0;
    end

    assign rd0 = rv[ra0];
    assign rd1 = rv[ra1];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  word_t          a,
    input  word_t          b,
    input  addr_t          imm,
    output word_t          res,
    output word_t          rem,
    output flags_t         flg
);
    logic [DW:0]     sum;
    logic [2*DW-1:0] prod;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

    always_comb begin
        res = '0;
        rem = '0;
        flg = '0;
        case (opcode_e'(op))
            OP_ADD: begin
                if (sum[DW]) flg.v = 1'b1;
                else         res   = sum[DW-1:0];
            end
            OP_SUB: begin
                if (b > a) flg.v = 1'b1;
                else       res   = a - b;
            end
            OP_MUL: begin
                if (|prod[2*DW-1:DW]) flg.v = 1'b1;
                else                  res   = prod[DW-1:0];
            end
            OP_DIV: begin
                if (b == '0) begin
                    flg.v = 1'b1;
                end else begin
                    res = a / b;
                    rem = a % b;
                end
            end
            OP_MOVI: res = DW'(imm);
            OP_MOVR: res = b;
            OP_RS:   res = a >> imm;
            OP_LS:   res = a << imm;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_NOT:  res = ~b;
            OP_CMP: begin
                flg.lt = (a < b);
                flg.gt = (a > b);
                flg.eq = (a == b);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [AW-1:0]       load_addr,
    input  logic [DW-1:0]       load_data,
    input  logic [AW-1:0]       peek_addr,
    output logic [DW-1:0]       peek_data,
    output logic                retire_valid,
    output logic [AW-1:0]       retire_pc,
    output logic [NGPR*DW-1:0]  retire_gpr,
    output logic [DW-1:0]       retire_flags,
    output logic                halted
);
    state_e  st;
    word_t   ir;
    addr_t   pc;
    flags_t  flags;
    decode_t dec;

    word_t   mem_rdata;
    addr_t   mem_raddr;
    logic    mem_we;
    addr_t   mem_waddr;
    word_t   mem_wdata;

    word_t   rf_a, rf_b, opa, opb;
    word_t   alu_res, alu_rem;
    flags_t  alu_flg;

    logic    exec_now;
    logic    take_jump;
    addr_t   next_pc;
    logic    we0, we1;
    rcode_t  wa0;
    word_t   wd0;

    assign dec      = decode(ir);
    assign exec_now = (st == ST_EXEC);

    // Memory: fetch address during fetch, operand address during execute.
    assign mem_raddr = (st == ST_FETCH) ? pc : ir[AW-1:0];
    assign mem_we    = load_en | (exec_now & dec.is_st);
    assign mem_waddr = load_en ? load_addr : ir[AW-1:0];
    assign mem_wdata = load_en ? load_data : opa;

    cpu16_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    // Register file; code 111 reads the flag word instead.
    assign opa = (dec.ra == FLAGS_CODE) ? flags_word(flags) : rf_a;
    assign opb = (dec.rb == FLAGS_CODE) ? flags_word(flags) : rf_b;

    assign we0 = exec_now & (dec.wr_pair | (dec.wr & (dec.rd != FLAGS_CODE)));
    assign wa0 = dec.wr_pair ? rcode_t'(0) : dec.rd;
    assign wd0 = dec.is_ld ? mem_rdata : alu_res;
    assign we1 = exec_now & dec.wr_pair;

    cpu16_regfile #(.NREG(NGPR), .W(DW), .CW(RCW)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we0  (we0),
        .wa0  (wa0),
        .wd0  (wd0),
        .we1  (we1),
        .wa1  (rcode_t'(1)),
        .wd1  (alu_rem),
        .ra0  (dec.ra),
        .rd0  (rf_a),
        .ra1  (dec.rb),
        .rd1  (rf_b),
        .dump (retire_gpr)
    );

    cpu16_alu u_alu (
        .op  (ir[DW-1 -: OPW]),
        .a   (opa),
        .b   (opb),
        .imm (ir[AW-1:0]),
        .res (alu_res),
        .rem (alu_rem),
        .flg (alu_flg)
    );

    // Branch resolution uses the flags left by the previous instruction.
    always_comb begin
        take_jump = 1'b0;
        case (opcode_e'(ir[DW-1 -: OPW]))
            OP_JMP:  take_jump = 1'b1;
            OP_JLT:  take_jump = flags.lt;
            OP_JGT:  take_jump = flags.gt;
            OP_JE:   take_jump = flags.eq;
            default: take_jump = 1'b0;
        endcase
    end

    always_comb begin
        if (dec.is_halt)    next_pc = pc;
        else if (take_jump) next_pc = ir[AW-1:0];
        else                next_pc = pc + addr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_FETCH;
            pc           <= '0;
            ir           <= '0;
            flags        <= '0;
            retire_valid <= 1'b0;
            retire_pc    <= '0;
        end else begin
            retire_valid <= 1'b0;
            case (st)
                ST_FETCH: begin
                    ir <= mem_rdata;
                    st <= ST_EXEC;
                end
                ST_EXEC: begin
                    flags        <= alu_flg;
                    pc           <= next_pc;
                    retire_valid <= 1'b1;
                    retire_pc    <= pc;
                    st           <= dec.is_halt ? ST_HALT : ST_FETCH;
                end
                default: ;
            endcase
        end
    end

    assign retire_flags = flags_word(flags);
    assign halted       = (st == ST_HALT);
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
    import cpu16_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          retire_valid,
    input logic [AW-1:0] retire_pc,
    input logic [DW-1:0] retire_flags,
    input logic          halted,
    input logic          exec_now,
    input logic          take_jump,
    input logic          halt_op,
    input logic [AW-1:0] jump_addr,
    input logic [AW-1:0] pc
);
    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        retire_valid |=> !retire_valid);  // R12

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !retire_valid));  // R13

    AST_FLAG_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        retire_valid |-> (retire_flags[DW-1:NFLAG] == '0 && $onehot0(retire_flags[2:0])));  // R6

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && retire_pc == '0 && retire_flags == '0 && !halted && !retire_valid));  // R11

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (exec_now && take_jump && !halt_op) |=> (pc == $past(jump_addr)));  // R10

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (exec_now && !take_jump && !halt_op) |=> (pc == $past(pc) + 7'd1));  // R10
endmodule

bind cpu16_core cpu16_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .retire_valid (retire_valid),
    .retire_pc    (retire_pc),
    .retire_flags (retire_flags),
    .halted       (halted),
    .exec_now     (exec_now),
    .take_jump    (take_jump),
    .halt_op      (dec.is_halt),
    .jump_addr    (ir[6:0]),
    .pc           (pc)
);

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic [6:0]   load_addr = '0;
    logic [15:0]  load_data = '0;
    logic [6:0]   peek_addr = '0;
    logic [15:0]  peek_data;
    logic         retire_valid;
    logic [6:0]   retire_pc;
    logic [111:0] retire_gpr;
    logic [15:0]  retire_flags;
    logic         halted;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cpu16_core u0 (
        .clk          (clk),
        .rst          (rst),
        .load_en      (load_en),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .peek_addr    (peek_addr),
        .peek_data    (peek_data),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc),
        .retire_gpr   (retire_gpr),
        .retire_flags (retire_flags),
        .halted       (halted)
    );

    // Instruction-level model state
    logic [15:0] img [128];
    logic [15:0] mm  [128];
    logic [15:0] rr  [8];
    logic [6:0]  ipc;
    bit          ihalt;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'b00000, 5'b00001, 5'b00110:           return "R2";
            5'b00111:                               return "R3";
            5'b00010, 5'b01000, 5'b01001:           return "R4";
            5'b01010, 5'b01011, 5'b01100, 5'b01101: return "R5";
            5'b01110:                               return "R6";
            5'b00011:                               return "R8";
            5'b00100, 5'b00101:                     return "R9";
            5'b01111, 5'b11100, 5'b11101, 5'b11111: return "R10";
            5'b11010:                               return "R13";
            default:                                return "R14";
        endcase
    endfunction

    // One instruction of the model; fields per R1, flag rule per R7.
    task automatic iss_step();
        logic [15:0] ir, a, b, q, r;
        logic [16:0] s;
        logic [31:0] p;
        logic [4:0]  op;
        logic [3:0]  fl;
        logic [6:0]  npc;
        ir  = mm[ipc];
        op  = ir[15:11];
        fl  = 4'b0;
        npc = ipc + 7'd1;
        a   = rr[ir[5:3]];
        b   = rr[ir[2:0]];
        case (op)
            5'b00000: begin s = {1'b0, a} + {1'b0, b};
                if (s[16]) begin fl[3] = 1; rr[ir[8:6]] = 0; end else rr[ir[8:6]] = s[15:0]; end
            5'b00001: begin
                if (b > a) begin fl[3] = 1; rr[ir[8:6]] = 0; end else rr[ir[8:6]] = a - b; end
            5'b00110: begin p = {16'b0, a} * {16'b0, b};
                if (p[31:16] != 0) begin fl[3] = 1; rr[ir[8:6]] = 0; end else rr[ir[8:6]] = p[15:0]; end
            5'b00111: begin
                if (b == 0) begin fl[3] = 1; rr[0] = 0; rr[1] = 0; end
                else begin q = a / b; r = a % b; rr[0] = q; rr[1] = r; end end
            5'b00010: rr[ir[9:7]] = {9'b0, ir[6:0]};
            5'b01000: rr[ir[9:7]] = rr[ir[9:7]] >> ir[6:0];
            5'b01001: rr[ir[9:7]] = rr[ir[9:7]] << ir[6:0];
            5'b00011: rr[ir[5:3]] = b;
            5'b01101: rr[ir[5:3]] = ~b;
            5'b01010: rr[ir[8:6]] = a ^ b;
            5'b01011: rr[ir[8:6]] = a | b;
            5'b01100: rr[ir[8:6]] = a & b;
            5'b01110: fl = {1'b0, a < b, a > b, a == b};
            5'b00100: rr[ir[9:7]] = mm[ir[6:0]];
            5'b00101: mm[ir[6:0]] = rr[ir[9:7]];
            5'b01111: npc = ir[6:0];
            5'b11100: if (rr[7][2]) npc = ir[6:0];
            5'b11101: if (rr[7][1]) npc = ir[6:0];
            5'b11111: if (rr[7][0]) npc = ir[6:0];
            5'b11010: begin ihalt = 1; npc = ipc; end
            default: ;
        endcase
        rr[7] = {12'b0, fl};
        ipc   = npc;
    endtask

    // Load img, reset, run until halt or max_ret retires, compare each retire.
    task automatic run_prog(input string name, input int max_ret);
        int gap, nret, cyc;
        bit gap_bad;
        logic [6:0]   epc;
        logic [111:0] eg;
        logic [4:0]   op;
        rst = 1'b1;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 7'(i);
            load_data = img[i];
            mm[i]     = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        for (int i = 0; i < 8; i++) rr[i] = '0;
        ipc = '0; ihalt = 0;
        // R11: reset state
        check(!halted && !retire_valid && retire_gpr == '0 && retire_flags == '0,
              "R11", {name, " reset state"},
              {halted, retire_valid, retire_flags}, 128'd0);
        rst = 1'b0;
        gap = 0; nret = 0; cyc = 0; gap_bad = 0;
        while (!ihalt && nret < max_ret && cyc < 4000) begin
            @(negedge clk);
            gap++; cyc++;
            if (retire_valid) begin
                if (gap != 2) gap_bad = 1;
                gap = 0; nret++;
                op  = mm[ipc][15:11];
                epc = ipc;
                iss_step();
                for (int i = 0; i < 7; i++) eg[i*16 +: 16] = rr[i];
                check(retire_pc == epc && retire_gpr == eg && retire_flags == rr[7] && halted == ihalt,
                      req_of(op), $sformatf("%s retire pc=%0d (fields R1, flags R7)", name, epc),
                      {retire_pc, retire_flags, halted, retire_gpr[95:0]},
                      {epc, rr[7], ihalt, eg[95:0]});
            end
        end
        check(!gap_bad && cyc < 4000, "R12", {name, " two cycles per retire"},
              128'(gap_bad), 128'd0);
        if (ihalt) begin
            bit quiet;
            quiet = 1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (retire_valid || !halted) quiet = 0;
            end
            check(quiet, "R13", {name, " frozen after halt"}, 128'(quiet), 128'd1);
            begin
                int bad_words;
                logic [15:0] first_act, first_exp;
                bad_words = 0; first_act = '0; first_exp = '0;
                for (int i = 0; i < 128; i++) begin
                    peek_addr = 7'(i);
                    #1;
                    if (peek_data !== mm[i]) begin
                        if (bad_words == 0) begin first_act = peek_data; first_exp = mm[i]; end
                        bad_words++;
                    end
                end
                check(bad_words == 0, "R9", {name, " memory dump"},
                      128'(first_act), 128'(first_exp));
            end
        end
    endtask

    function automatic logic [15:0] enc_a(logic [4:0] op, int d, int x, int y);
        return {op, 2'b00, 3'(d), 3'(x), 3'(y)};
    endfunction
    function automatic logic [15:0] enc_b(logic [4:0] op, int d, int v);
        return {op, 1'b0, 3'(d), 7'(v)};
    endfunction
    function automatic logic [15:0] enc_c(logic [4:0] op, int x, int y);
        return {op, 5'b00000, 3'(x), 3'(y)};
    endfunction
    function automatic logic [15:0] enc_e(logic [4:0] op, int t);
        return {op, 4'b0000, 7'(t)};
    endfunction

    // Random legal or undefined instruction; unused bits carry junk (R1).
    function automatic logic [15:0] gen_instr(int pc, int last);
        logic [15:0] w;
        logic [4:0]  la [6] = '{5'b00000, 5'b00001, 5'b00110, 5'b01010, 5'b01011, 5'b01100};
        logic [4:0]  lb [3] = '{5'b00010, 5'b01000, 5'b01001};
        logic [4:0]  lc [4] = '{5'b00011, 5'b01101, 5'b01110, 5'b00111};
        logic [4:0]  le [4] = '{5'b01111, 5'b11100, 5'b11101, 5'b11111};
        logic [4:0]  lx [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10110,
                                5'b11000, 5'b11001, 5'b11011, 5'b11110};
        int sel;
        w   = 16'($urandom);
        sel = int'($urandom_range(99, 0));
        if (sel < 30) begin
            w[15:11] = la[$urandom_range(5, 0)];
            w[8:6]   = 3'($urandom_range(6, 0));
        end else if (sel < 45) begin
            w[15:11] = lb[$urandom_range(2, 0)];
            w[9:7]   = 3'($urandom_range(6, 0));
            if (w[15:11] != 5'b00010 && $urandom_range(3, 0) != 0)
                w[6:0] = 7'($urandom_range(18, 0));
        end else if (sel < 65) begin
            w[15:11] = lc[$urandom_range(3, 0)];
            if (w[15:11] != 5'b01110 && w[15:11] != 5'b00111)
                w[5:3] = 3'($urandom_range(6, 0));
            else if ($urandom_range(3, 0) == 0)
                w[2:0] = w[5:3];
        end else if (sel < 78) begin
            w[15:11] = ($urandom_range(1, 0) == 0) ? 5'b00100 : 5'b00101;
            w[9:7]   = 3'($urandom_range(6, 0));
            w[6:0]   = (w[15:11] == 5'b00100) ? 7'($urandom_range(127, 41))
                                              : 7'($urandom_range(127, 48));
        end else if (sel < 93) begin
            w[15:11] = le[$urandom_range(3, 0)];
            w[6:0]   = 7'($urandom_range(last, pc + 1));
        end else begin
            w[15:11] = lx[$urandom_range(7, 0)];
        end
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);

        // Directed: overflow, FLAGS read, compares, jumps, divide by zero, shifts, ld/st.
        for (int i = 0; i < 128; i++) img[i] = '0;
        img[0]  = enc_b(5'b00010, 1, 100);
        img[1]  = enc_b(5'b00010, 2, 127);
        img[2]  = enc_a(5'b00110, 3, 1, 2);      // R2 no overflow
        img[3]  = enc_a(5'b00110, 4, 3, 3);      // R2 overflow
        img[4]  = enc_c(5'b00011, 5, 7);         // R8 FLAGS copy
        img[5]  = enc_c(5'b01110, 1, 2);         // R6 less
        img[6]  = enc_e(5'b11100, 8);            // R10 taken
        img[7]  = enc_b(5'b00010, 6, 1);
        img[8]  = enc_c(5'b00111, 3, 1);         // R3
        img[9]  = enc_c(5'b00111, 2, 6);         // R3 zero divisor
        img[10] = enc_e(5'b11101, 12);           // R10 not taken
        img[11] = enc_a(5'b00001, 4, 0, 2);      // R2 underflow
        img[12] = enc_b(5'b01001, 2, 16);        // R4 shift out
        img[13] = enc_b(5'b00010, 6, 127) | 16'h0400;
        img[14] = enc_b(5'b00101, 6, 100);       // R9
        img[15] = enc_b(5'b00100, 5, 100);
        img[16] = enc_c(5'b01110, 5, 6);         // R6 equal
        img[17] = enc_e(5'b11111, 19);
        img[18] = enc_b(5'b00010, 0, 5);
        img[19] = enc_b(5'b01000, 5, 3);
        img[20] = 16'hD000;                      // hlt
        run_prog("directed", 1000);

        // Directed: PC wrap from 127 to 0 (R10).
        for (int i = 0; i < 128; i++) img[i] = '0;
        img[0]   = enc_c(5'b01110, 0, 0);
        img[1]   = enc_e(5'b11111, 127);
        img[127] = enc_b(5'b00010, 3, 7);
        run_prog("wrap", 5);

        // Random programs
        for (int t = 0; t < 40; t++) begin
            int last;
            last = int'($urandom_range(40, 8));
            for (int i = 0; i < 128; i++) img[i] = (i > 40) ? 16'($urandom) : 16'h0000;
            for (int i = 0; i < last; i++) img[i] = gen_instr(i, last);
            img[last] = 16'hD000 | 16'($urandom_range(2047, 0));
            run_prog($sformatf("rand%0d", t), 1000);
        end

        report();
        $finish;
    end
endmodule